// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a small processor core that finishes one instruction in every clock cycle. It covers a subset of a 32-bit load/store integer instruction set: register-to-register arithmetic and logic, immediate arithmetic and logic, upper-immediate load, signed compare, zero-extending byte and halfword loads, word loads, stores of a byte, a halfword or a word, two conditional branches, direct jumps, a jump that links, and a jump through a register. It holds 32 general registers, and register 0 always reads as zero.

The core fetches from a word-addressed instruction port and reaches data through a separate word-addressed data port. Both ports are read combinationally within the cycle. Data writes are committed on the clock edge, under a four-bit lane enable. Byte lanes are numbered big-endian. Two outputs report problems with the current instruction. One flags signed overflow on the trapping add and subtract forms. The other flags an instruction whose encoding is outside the implemented set. Neither output redirects the program. Each only prevents that instruction from changing any state.

Top module: `sc_int_core`

## Requirements
- R1: With opcode 0 the funct field selects the operation: 0x20 add, 0x21 addu, 0x22 sub, 0x23 subu, 0x24 and, 0x25 or, 0x27 nor (NOT of OR), 0x2a slt (signed compare, writes 1 or 0). The result goes to the register named in bits [15:11], and the sources are bits [25:21] and [20:16].
- R2: Immediate forms write the register named in bits [20:16]. addi (0x08) and addiu (0x09) sign-extend bit 15 of the immediate. andi (0x0c) and ori (0x0d) zero-extend it. lui (0x0f) places the immediate in bits [31:16] and fills bits [15:0] with zeros.
- R3: add, addi and sub raise ovf_flag during the cycle of an instruction that overflows as a signed operation, and in that case the destination is not written. addu, addiu and subu never raise ovf_flag and always write.
- R4: Reads of register 0 return zero, and writes to register 0 are discarded.
- R5: lw (0x23), lbu (0x24) and lhu (0x25) read at rs plus the sign-extended immediate. lbu returns the byte chosen by address bits [1:0], where offset 0 is data bits [31:24]. lhu returns bits [31:16] when address bit 1 is 0 and bits [15:0] when it is 1. Both zero-extend the value to 32 bits.
- R6: sw (0x2b) enables all four lanes. sh (0x29) enables lanes 3 and 2 (dmem_be 4'b1100) when address bit 1 is 0, and lanes 1 and 0 (4'b0011) when it is 1. sb (0x28) enables exactly lane 3 minus the byte offset. Every enabled lane carries the low bits of rt.
- R7: beq (0x04) and bne (0x05) move the PC to PC+4 plus the sign-extended immediate shifted left by two when rs equal to rt (beq) or not equal (bne) holds, and otherwise move it to PC+4.
- R8: j (0x02) and jal (0x03) jump to bits [31:28] of PC+4 joined with the 26-bit field and two zero bits. jal also writes PC+8 to register 31.
- R9: jr (opcode 0, funct 0x08) loads the PC from rs and writes no register.
- R10: An opcode or funct value outside R1 to R9 raises illegal_instr for that cycle, writes no register and no memory, and advances the PC by 4.
- R11: While reset is held, and for two clock cycles after it is released, the PC stays at RESET_PC (0 by default) and no register is written.
- R12: Any instruction that is not a jump or a taken branch advances the PC by exactly 4, so stores appear on the data port in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| imem_addr | output | 30 | Word address of the instruction being fetched (PC bits [31:2]) |
| imem_rdata | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 30 | Word address of the load or store |
| dmem_wdata | output | 32 | Store data, already replicated across lanes |
| dmem_be | output | 4 | Lane write enables, bit 3 is byte offset 0 (data bits [31:24]) |
| dmem_we | output | 1 | Store strobe, committed at the rising clock edge |
| dmem_rdata | input | 32 | Data word at dmem_addr, valid in the same cycle |
| ovf_flag | output | 1 | Signed overflow on a trapping add or subtract in this cycle |
| illegal_instr | output | 1 | Current instruction is not in the implemented set |

## Verification
The hardest behaviour to observe is a write that does not happen: an overflowing add or subtract, an illegal encoding, or a write to register 0. The register file cannot be seen from the ports. The stimulus therefore aims each of these instructions at a fresh register that still holds its reset value of zero, and then stores that register to memory, where a zero word proves the write was suppressed. Skipped instructions after taken branches and jumps are stores placed in the shadow of the branch. The scoreboard treats any data write it did not predict as a failure, so a branch or jump that falls through becomes visible at the port.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  // primary opcodes
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_ANDI  = 6'h0c;
  localparam logic [5:0] OP_ORI   = 6'h0d;
  localparam logic [5:0] OP_LUI   = 6'h0f;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_LBU   = 6'h24;
  localparam logic [5:0] OP_LHU   = 6'h25;
  localparam logic [5:0] OP_SB    = 6'h28;
  localparam logic [5:0] OP_SH    = 6'h29;
  localparam logic [5:0] OP_SW    = 6'h2b;

  // function codes under OP_RTYPE
  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2a;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {
    MW_NONE, MW_BYTE, MW_HALF, MW_WORD
  } mem_w_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    imm_src;   // second operand from immediate
    logic    imm_zext;  // zero-extend instead of sign-extend
    logic    dst_rd;    // destination from bits [15:11]
    logic    reg_we;
    logic    link;      // write PC+8 to the link register
    mem_w_e  ld;
    mem_w_e  st;
    logic    br_eq;
    logic    br_ne;
    logic    jmp;
    logic    jreg;
    logic    trap_ovf;
    logic    illegal;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    ctrl.ld     = MW_NONE;
    ctrl.st     = MW_NONE;
    case (opc)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        case (fn)
          FN_ADD:  begin ctrl.alu_op = ALU_ADD; ctrl.trap_ovf = 1'b1; end
          FN_ADDU: ctrl.alu_op = ALU_ADD;
          FN_SUB:  begin ctrl.alu_op = ALU_SUB; ctrl.trap_ovf = 1'b1; end
          FN_SUBU: ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_NOR:  ctrl.alu_op = ALU_NOR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          FN_JR:   begin ctrl.reg_we = 1'b0; ctrl.jreg = 1'b1; end
          default: begin
            ctrl.reg_we  = 1'b0;
            ctrl.dst_rd  = 1'b0;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      OP_ADDI: begin
        ctrl.imm_src  = 1'b1;
        ctrl.reg_we   = 1'b1;
        ctrl.trap_ovf = 1'b1;
      end
      OP_ADDIU: begin
        ctrl.imm_src = 1'b1;
        ctrl.reg_we  = 1'b1;
      end
      OP_ANDI: begin
        ctrl.imm_src  = 1'b1;
        ctrl.imm_zext = 1'b1;
        ctrl.alu_op   = ALU_AND;
        ctrl.reg_we   = 1'b1;
      end
      OP_ORI: begin
        ctrl.imm_src  = 1'b1;
        ctrl.imm_zext = 1'b1;
        ctrl.alu_op   = ALU_OR;
        ctrl.reg_we   = 1'b1;
      end
      OP_LUI: begin
        ctrl.imm_src = 1'b1;
        ctrl.alu_op  = ALU_LUI;
        ctrl.reg_we  = 1'b1;
      end
      OP_LW:  begin ctrl.imm_src = 1'b1; ctrl.reg_we = 1'b1; ctrl.ld = MW_WORD; end
      OP_LBU: begin ctrl.imm_src = 1'b1; ctrl.reg_we = 1'b1; ctrl.ld = MW_BYTE; end
      OP_LHU: begin ctrl.imm_src = 1'b1; ctrl.reg_we = 1'b1; ctrl.ld = MW_HALF; end
      OP_SB:  begin ctrl.imm_src = 1'b1; ctrl.st = MW_BYTE; end
      OP_SH:  begin ctrl.imm_src = 1'b1; ctrl.st = MW_HALF; end
      OP_SW:  begin ctrl.imm_src = 1'b1; ctrl.st = MW_WORD; end
      OP_BEQ: ctrl.br_eq = 1'b1;
      OP_BNE: ctrl.br_ne = 1'b1;
      OP_J:   ctrl.jmp = 1'b1;
      OP_JAL: begin
        ctrl.jmp    = 1'b1;
        ctrl.link   = 1'b1;
        ctrl.reg_we = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         sovf
);

  localparam int HALF = W / 2;

  logic [W-1:0] sum;
  logic [W-1:0] dif;

  assign sum = opa + opb;
  assign dif = opa - opb;

  always_comb begin
    sovf = 1'b0;
    case (op)
      ALU_ADD: begin
        res  = sum;
        sovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
      end
      ALU_SUB: begin
        res  = dif;
        sovf = (opa[W-1] != opb[W-1]) && (dif[W-1] != opa[W-1]);
      end
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_NOR: res = ~(opa | opb);
      ALU_SLT: res = ($signed(opa) < $signed(opb)) ? W'(1) : '0;
      ALU_LUI: res = {opb[HALF-1:0], {HALF{1'b0}}};
      default: res = sum;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0]    q [NREG];
  logic [NREG-1:0] wr_en;

  // next-state: one enable per entry, entry 0 never enabled
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wr_en[i] = we && (i != 0) && (waddr == AW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en[i]) q[i] <= wdata;
      end
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : q[raddr_b];

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> ((raddr_a != $past(waddr)) || (rdata_a == $past(wdata)))); // R4

endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc #(
  parameter int W = 32,
  localparam int JW = W - 6
) (
  input  logic [W-1:0]  pc,
  input  logic [15:0]   imm16,
  input  logic [JW-1:0] jfield,
  input  logic [W-1:0]  rs_val,
  input  logic          rs_eq_rt,
  input  logic          br_eq,
  input  logic          br_ne,
  input  logic          jmp,
  input  logic          jreg,
  output logic [W-1:0]  pc_plus4,
  output logic [W-1:0]  pc_next,
  output logic          br_taken
);

  logic [W-1:0] br_off;
  logic [W-1:0] br_tgt;
  logic [W-1:0] j_tgt;

  assign pc_plus4 = pc + W'(4);
  assign br_off   = {{(W-18){imm16[15]}}, imm16, 2'b00};
  assign br_tgt   = pc_plus4 + br_off;
  assign j_tgt    = {pc_plus4[W-1:W-4], jfield, 2'b00};
  assign br_taken = (br_eq && rs_eq_rt) || (br_ne && !rs_eq_rt);

  always_comb begin
    if (jreg)          pc_next = rs_val;
    else if (jmp)      pc_next = j_tgt;
    else if (br_taken) pc_next = br_tgt;
    else               pc_next = pc_plus4;
  end

endmodule

// File: rtl/sc_int_core.sv
module sc_int_core
  import sc_core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [29:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [29:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic [3:0]  dmem_be,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        ovf_flag,
  output logic        illegal_instr
);

  localparam int HALF = XLEN / 2;
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREG - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // program counter
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4;
  logic            br_taken;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) pc_q <= RESET_PC;
    else           pc_q <= pc_d;
  end

  assign imem_addr = pc_q[XLEN-1:2];

  // decode
  logic [XLEN-1:0]   instr;
  ctrl_t             ctrl;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx;
  logic [15:0]       imm16;

  assign instr  = imem_rdata;
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign imm16  = instr[15:0];

  sc_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  // registers
  logic [XLEN-1:0]   rs_val, rt_val, rf_wdata;
  logic [RIDX_W-1:0] rf_waddr;
  logic              rf_we;

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  // execute
  logic [XLEN-1:0] imm_sext, imm_ext, alu_b, alu_res;
  logic            alu_ovf;

  assign imm_sext = {{HALF{imm16[15]}}, imm16};
  assign imm_ext  = ctrl.imm_zext ? {{HALF{1'b0}}, imm16} : imm_sext;
  assign alu_b    = ctrl.imm_src ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .opa  (rs_val),
    .opb  (alu_b),
    .op   (ctrl.alu_op),
    .res  (alu_res),
    .sovf (alu_ovf)
  );

  sc_nextpc #(.W(XLEN)) u_npc (
    .pc       (pc_q),
    .imm16    (imm16),
    .jfield   (instr[XLEN-7:0]),
    .rs_val   (rs_val),
    .rs_eq_rt (rs_val == rt_val),
    .br_eq    (ctrl.br_eq),
    .br_ne    (ctrl.br_ne),
    .jmp      (ctrl.jmp),
    .jreg     (ctrl.jreg),
    .pc_plus4 (pc_plus4),
    .pc_next  (pc_d),
    .br_taken (br_taken)
  );

  // data port: big-endian lanes, bit 3 of the enable is byte offset 0
  logic [1:0]      boff;
  logic [XLEN-1:0] ld_lane, ld_val;

  assign boff      = alu_res[1:0];
  assign dmem_addr = alu_res[XLEN-1:2];
  assign ld_lane   = dmem_rdata << {boff, 3'b000};

  always_comb begin
    case (ctrl.ld)
      MW_BYTE: ld_val = {24'b0, ld_lane[31:24]};
      MW_HALF: ld_val = boff[1] ? {16'b0, dmem_rdata[15:0]} : {16'b0, dmem_rdata[31:16]};
      default: ld_val = dmem_rdata;
    endcase
  end

  always_comb begin
    case (ctrl.st)
      MW_BYTE: begin
        dmem_be    = 4'b1000 >> boff;
        dmem_wdata = {4{rt_val[7:0]}};
      end
      MW_HALF: begin
        dmem_be    = boff[1] ? 4'b0011 : 4'b1100;
        dmem_wdata = {2{rt_val[15:0]}};
      end
      MW_WORD: begin
        dmem_be    = 4'b1111;
        dmem_wdata = rt_val;
      end
      default: begin
        dmem_be    = 4'b0000;
        dmem_wdata = rt_val;
      end
    endcase
  end

  assign dmem_we = (ctrl.st != MW_NONE) && !ctrl.illegal;

  // write-back
  assign ovf_flag      = ctrl.trap_ovf && alu_ovf;
  assign illegal_instr = ctrl.illegal;
  assign rf_we         = ctrl.reg_we && !ovf_flag && !ctrl.illegal;

  always_comb begin
    if (ctrl.link)        rf_waddr = LINK_REG;
    else if (ctrl.dst_rd) rf_waddr = rd_idx;
    else                  rf_waddr = rt_idx;
  end

  always_comb begin
    if (ctrl.link)               rf_wdata = pc_plus4 + XLEN'(4);
    else if (ctrl.ld != MW_NONE) rf_wdata = ld_val;
    else                         rf_wdata = alu_res;
  end

  // checks
  AST_NO_WRITE_ON_OVF: assert property (@(posedge clk) disable iff (!rst_sync)
    ovf_flag |-> !rf_we); // R3

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
    illegal_instr |-> (!rf_we && !dmem_we)); // R10

  AST_STORE_LANES: assert property (@(posedge clk) disable iff (!rst_sync)
    dmem_we |-> ($countones(dmem_be) == 1 || dmem_be == 4'b1100 ||
                 dmem_be == 4'b0011 || dmem_be == 4'b1111)); // R6

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_sync)
    (rf_we && ctrl.link) |-> (rf_waddr == LINK_REG && rf_wdata == pc_q + XLEN'(8))); // R8

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_sync)
    !(ctrl.jmp || ctrl.jreg || br_taken) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R12

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_sync)
    ((ctrl.br_eq || ctrl.br_ne) && br_taken) |=>
      (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_sext[XLEN-3:0]), 2'b00})); // R7

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync)
    !ctrl.jreg |=> (pc_q[1:0] == 2'b00)); // R12

endmodule

// File: tb/sim_sc_int_core.sv
module sim_sc_int_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [29:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic [3:0]  dmem_be;
  logic        dmem_we;
  logic [31:0] dmem_rdata;
  logic        ovf_flag;
  logic        illegal_instr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sc_int_core u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .imem_addr     (imem_addr),
    .imem_rdata    (imem_rdata),
    .dmem_addr     (dmem_addr),
    .dmem_wdata    (dmem_wdata),
    .dmem_be       (dmem_be),
    .dmem_we       (dmem_we),
    .dmem_rdata    (dmem_rdata),
    .ovf_flag      (ovf_flag),
    .illegal_instr (illegal_instr)
  );

  // memories
  logic [31:0] imem [64];
  logic [31:0] dmem [32];

  assign imem_rdata = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[4:0]];

  always @(posedge clk) begin
    if (dmem_we) begin
      for (int b = 0; b < 4; b++) begin
        if (dmem_be[b]) dmem[dmem_addr[4:0]][b*8 +: 8] <= dmem_wdata[b*8 +: 8];
      end
    end
  end

  // encoders
  function automatic logic [31:0] r_ins(input logic [5:0] fn, input int rs, input int rt, input int rd);
    r_ins = {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction

  function automatic logic [31:0] i_ins(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    i_ins = {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] j_ins(input logic [5:0] op, input int word);
    j_ins = {op, 26'(word)};
  endfunction

  // scoreboard
  typedef struct packed {
    logic [29:0] idx;
    logic [3:0]  be;
    logic [31:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  task automatic push_exp(input int idx, input logic [3:0] be, input logic [31:0] data, input string tag);
    exp_q.push_back({30'(idx), be, data});
    tag_q.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    for (int b = 0; b < 4; b++) lane_mask[b*8 +: 8] = {8{be[b]}};
  endfunction

  // monitor: store scoreboard plus per-PC flag checks
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dmem_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected store", {2'b00, dmem_addr}, 32'hffffffff);
        end else begin
          exp_t  e;
          string t;
          logic [31:0] m;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          m = lane_mask(e.be);
          check(dmem_addr == e.idx, {t, " address"}, {2'b00, dmem_addr}, {2'b00, e.idx});
          check(dmem_be == e.be, {t, " lanes"}, {28'b0, dmem_be}, {28'b0, e.be});
          check((dmem_wdata & m) == (e.data & m), {t, " data"}, dmem_wdata & m, e.data & m);
        end
      end
      case (imem_addr)
        30'd22: check(ovf_flag == 1'b1, "R3 add overflow flag", {31'b0, ovf_flag}, 32'd1);
        30'd23: check(ovf_flag == 1'b0, "R3 addu no flag", {31'b0, ovf_flag}, 32'd0);
        30'd25: check(ovf_flag == 1'b1, "R3 sub overflow flag", {31'b0, ovf_flag}, 32'd1);
        30'd26: check(ovf_flag == 1'b0, "R3 addiu no flag", {31'b0, ovf_flag}, 32'd0);
        30'd27: check(ovf_flag == 1'b1, "R3 addi overflow flag", {31'b0, ovf_flag}, 32'd1);
        30'd33: check(illegal_instr == 1'b1, "R10 bad opcode", {31'b0, illegal_instr}, 32'd1);
        30'd34: check(illegal_instr == 1'b1, "R10 bad funct", {31'b0, illegal_instr}, 32'd1);
        30'd35: check(illegal_instr == 1'b0, "R10 legal store", {31'b0, illegal_instr}, 32'd0);
        default: ;
      endcase
    end
  end

  // driver
  initial begin
    for (int k = 0; k < 64; k++) imem[k] = 32'h0;
    for (int k = 0; k < 32; k++) dmem[k] = 32'h0;

    imem[0]  = i_ins(6'h0f, 0, 1, 16'h1234);          // lui r1
    imem[1]  = i_ins(6'h0d, 1, 1, 16'h8765);          // ori r1
    imem[2]  = i_ins(6'h2b, 0, 1, 16'd0);             // sw r1
    imem[3]  = i_ins(6'h08, 0, 2, 16'hfffc);          // addi r2 = -4
    imem[4]  = i_ins(6'h2b, 0, 2, 16'd4);
    imem[5]  = i_ins(6'h0c, 2, 3, 16'hff0f);          // andi r3
    imem[6]  = i_ins(6'h2b, 0, 3, 16'd8);
    imem[7]  = r_ins(6'h20, 1, 3, 4);                 // add
    imem[8]  = r_ins(6'h22, 1, 3, 5);                 // sub
    imem[9]  = r_ins(6'h27, 1, 3, 6);                 // nor
    imem[10] = r_ins(6'h2a, 2, 0, 7);                 // slt
    imem[11] = i_ins(6'h2b, 0, 4, 16'd12);
    imem[12] = i_ins(6'h2b, 0, 5, 16'd16);
    imem[13] = i_ins(6'h2b, 0, 6, 16'd20);
    imem[14] = i_ins(6'h2b, 0, 7, 16'd24);
    imem[15] = i_ins(6'h28, 0, 1, 16'd29);            // sb offset 1
    imem[16] = i_ins(6'h29, 0, 1, 16'd34);            // sh offset 2
    imem[17] = i_ins(6'h24, 0, 8, 16'd2);             // lbu offset 2
    imem[18] = i_ins(6'h25, 0, 9, 16'd2);             // lhu offset 2
    imem[19] = i_ins(6'h2b, 0, 8, 16'd36);
    imem[20] = i_ins(6'h2b, 0, 9, 16'd40);
    imem[21] = i_ins(6'h0f, 0, 11, 16'h7fff);
    imem[22] = r_ins(6'h20, 11, 11, 12);              // add overflows
    imem[23] = r_ins(6'h21, 11, 11, 13);              // addu
    imem[24] = i_ins(6'h0f, 0, 15, 16'h8000);
    imem[25] = r_ins(6'h22, 15, 1, 16);               // sub overflows
    imem[26] = i_ins(6'h09, 15, 17, 16'hffff);        // addiu wraps
    imem[27] = i_ins(6'h08, 15, 18, 16'hffff);        // addi overflows
    imem[28] = i_ins(6'h2b, 0, 12, 16'd44);
    imem[29] = i_ins(6'h2b, 0, 13, 16'd48);
    imem[30] = i_ins(6'h2b, 0, 16, 16'd52);
    imem[31] = i_ins(6'h2b, 0, 17, 16'd56);
    imem[32] = i_ins(6'h2b, 0, 18, 16'd60);
    imem[33] = i_ins(6'h3f, 0, 19, 16'h1234);         // bad opcode
    imem[34] = r_ins(6'h01, 1, 1, 20);                // bad funct
    imem[35] = i_ins(6'h2b, 0, 19, 16'd64);
    imem[36] = i_ins(6'h2b, 0, 20, 16'd68);
    imem[37] = i_ins(6'h09, 0, 0, 16'd5);             // addiu r0
    imem[38] = i_ins(6'h2b, 0, 0, 16'd72);
    imem[39] = i_ins(6'h04, 0, 0, 16'd2);             // beq taken to 42
    imem[40] = i_ins(6'h2b, 0, 1, 16'd76);            // shadow
    imem[41] = i_ins(6'h2b, 0, 1, 16'd76);            // shadow
    imem[42] = i_ins(6'h05, 0, 0, 16'd5);             // bne not taken
    imem[43] = i_ins(6'h05, 1, 0, 16'd1);             // bne taken to 45
    imem[44] = i_ins(6'h2b, 0, 1, 16'd80);            // shadow
    imem[45] = j_ins(6'h03, 50);                      // jal
    imem[46] = i_ins(6'h2b, 0, 1, 16'd88);            // shadow
    imem[47] = i_ins(6'h2b, 0, 31, 16'd84);           // return point
    imem[48] = j_ins(6'h02, 52);                      // j
    imem[49] = i_ins(6'h2b, 0, 1, 16'd88);            // shadow
    imem[50] = r_ins(6'h08, 31, 0, 0);                // jr r31
    imem[51] = i_ins(6'h2b, 0, 1, 16'd88);            // shadow
    imem[52] = i_ins(6'h04, 0, 0, 16'hffff);          // spin

    push_exp(0,  4'hf, 32'h12348765, "R2 lui+ori zero-extended");
    push_exp(1,  4'hf, 32'hfffffffc, "R2 addi sign-extended");
    push_exp(2,  4'hf, 32'hfffffffc & 32'h0000ff0f, "R2 andi zero-extended");
    push_exp(3,  4'hf, 32'h12348765 + 32'h0000ff0c, "R1 add");
    push_exp(4,  4'hf, 32'h12348765 - 32'h0000ff0c, "R1 sub");
    push_exp(5,  4'hf, ~(32'h12348765 | 32'h0000ff0c), "R1 nor");
    push_exp(6,  4'hf, 32'd1, "R1 slt signed");
    push_exp(7,  4'b0100, 32'h00650000, "R6 sb offset 1");
    push_exp(8,  4'b0011, 32'h00008765, "R6 sh offset 2");
    push_exp(9,  4'hf, 32'h00000087, "R5 lbu big-endian");
    push_exp(10, 4'hf, 32'h00008765, "R5 lhu low half");
    push_exp(11, 4'hf, 32'h0, "R3 add write suppressed");
    push_exp(12, 4'hf, 32'hfffe0000, "R3 addu writes");
    push_exp(13, 4'hf, 32'h0, "R3 sub write suppressed");
    push_exp(14, 4'hf, 32'h7fffffff, "R3 addiu writes");
    push_exp(15, 4'hf, 32'h0, "R3 addi write suppressed");
    push_exp(16, 4'hf, 32'h0, "R10 opcode no write");
    push_exp(17, 4'hf, 32'h0, "R10 funct no write");
    push_exp(18, 4'hf, 32'h0, "R4 r0 reads zero");
    push_exp(21, 4'hf, 32'd188, "R8 jal link, R9 jr return");

    // R11: reset state
    repeat (3) @(negedge clk);
    check(imem_addr == 30'd0, "R11 pc in reset", {2'b00, imem_addr}, 32'd0);
    check(dmem_we == 1'b0, "R11 no store in reset", {31'b0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(imem_addr == 30'd0, "R11 pc held after release", {2'b00, imem_addr}, 32'd0);

    repeat (150) @(negedge clk);
    check(exp_q.size() == 0, "R12 all stores in order", 32'(exp_q.size()), 32'd0);
    check(imem_addr == 30'd52, "R7 branch spin reached", {2'b00, imem_addr}, 32'd52);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule